// File: doc/BRIEF.md
# Static Conditional Branch Predictor

This block chooses a direction for a conditional branch when the branch is decoded, and it settles the cycle cost once the real outcome is known. A branch that jumps backward is always guessed taken. A branch that jumps forward follows a run-time control bit taken from the condition code register. When that bit is 1 the forward branch is guessed taken. When it is 0 the forward branch is guessed not taken.

The prediction is stored when the branch is accepted and held until the outcome comes back. When the outcome is presented, the block reports the cost of the branch in that same cycle: 1 cycle for a correct guess and 5 cycles for a wrong one. A wrong guess also raises a one-cycle mispredict flag. The block then loads a stall counter that covers the 4 extra cycles, and fetch-ready stays low until that counter drains. The block does not compute the target address and keeps no history. The condition codes are resolved outside the block.

The reset input is asynchronous and active low. It is expected to be released synchronously to `clk` by the reset tree that feeds the block.

Top module: `sbp_top`

## Requirements
- R1: After reset, pred_taken_o is 0, mispredict_o is 0, cost_o is 0, stall_cnt_o is 0 and fetch_rdy_o is 1.
- R2: An accepted branch whose displacement is negative in two's complement (top bit 1) gives pred_taken_o = 1 from the next cycle on, whatever the value of fwd_ctl_i.
- R3: An accepted branch whose displacement is zero or positive gives pred_taken_o equal to the fwd_ctl_i value sampled with it, from the next cycle on.
- R4: A branch is accepted when br_valid_i is high and no resolution is pending. pred_taken_o holds its value until the next accepted branch. A br_valid_i that arrives while a resolution is pending is ignored.
- R5: mispredict_o is high in exactly the cycle in which res_valid_i is high with a resolution pending and res_taken_i differs from the held prediction. It is low in every other cycle.
- R6: In a cycle that resolves a pending branch, cost_o is 1 for a correct prediction and 5 for a mispredict. In every other cycle cost_o is 0.
- R7: The cycle after a mispredict, stall_cnt_o is 4. It then falls by 1 each cycle down to 0. fetch_rdy_o is 1 exactly when stall_cnt_o is 0. A new mispredict reloads the counter to 4.
- R8: A res_valid_i with no resolution pending is ignored: no mispredict, cost_o stays 0 and the stall counter is not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | A decoded conditional branch is present |
| br_disp_i | input | DISP_W | Signed branch displacement |
| fwd_ctl_i | input | 1 | Forward-branch prediction control bit from the condition code register |
| res_valid_i | input | 1 | The resolved outcome is presented |
| res_taken_i | input | 1 | The resolved outcome: 1 means taken |
| pred_taken_o | output | 1 | The held predicted direction |
| mispredict_o | output | 1 | One-cycle flag that the resolved outcome differs from the prediction |
| cost_o | output | COST_W | Cycle cost of the branch being resolved, 0 when no branch resolves |
| stall_cnt_o | output | STALL_W | Penalty cycles left to wait |
| fetch_rdy_o | output | 1 | Fetch may proceed: no penalty cycles are left |

## Verification
mispredict_o and cost_o are combinational outputs, so they are checked in the same cycle as the res_valid_i that produces them. pred_taken_o and stall_cnt_o are registered, so they change one edge after the accept or the mispredict. The bench drives inputs just after the falling edge and compares every output with a behavioural model 1 ns later. The model's state advances only at the rising edge, so each result is compared in exactly the cycle it is due. The directed cases cover these situations:
- backward and forward branches, with zero counting as forward
- both settings of the control bit
- a branch offered while a resolution is pending
- a resolution with nothing pending
- a mispredict during a running stall countdown

A stretch of random traffic follows the directed cases.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  // Outcome of resolving a held branch.
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_HIT  = 2'd1,
    RES_MISS = 2'd2
  } res_kind_e;
endpackage

// File: rtl/sbp_dir.sv
// Static direction decision: a negative displacement is guessed taken;
// zero or positive follows the forward control bit.
module sbp_dir #(
  parameter int DISP_W = 16
) (
  input  logic [DISP_W-1:0] disp_i,
  input  logic              fwd_ctl_i,
  output logic              taken_o
);
  always_comb begin
    if ($signed(disp_i) < 0) taken_o = 1'b1;
    else                     taken_o = fwd_ctl_i;
  end
endmodule

// File: rtl/sbp_hold.sv
// Holds the pending flag and the registered prediction.
module sbp_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  input  logic resolve_i,
  input  logic pred_i,
  output logic pend_o,
  output logic pred_o
);
  logic pend_d, pred_d;
  logic pred_en;

  always_comb begin
    pend_d  = pend_o;
    if (resolve_i)     pend_d = 1'b0;
    else if (accept_i) pend_d = 1'b1;
    pred_en = accept_i;
    pred_d  = pred_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_o <= 1'b0;
    else        pend_o <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pred_o <= 1'b0;
    else if (pred_en) pred_o <= pred_d;
  end
endmodule

// File: rtl/sbp_penalty.sv
// Counts the extra penalty cycles after a mispredict.
module sbp_penalty #(
  parameter int EXTRA   = 4,
  parameter int STALL_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  output logic [STALL_W-1:0] cnt_o,
  output logic               rdy_o
);
  localparam logic [STALL_W-1:0] LOAD_VAL = STALL_W'(EXTRA);

  logic [STALL_W-1:0] cnt_d;
  logic               cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_o != '0);
    if (load_i) cnt_d = LOAD_VAL;
    else        cnt_d = cnt_o - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (cnt_en) cnt_o <= cnt_d;
  end

  assign rdy_o = (cnt_o == '0);
endmodule

// File: rtl/sbp_top.sv
module sbp_top #(
  parameter int DISP_W      = 16,
  parameter int HIT_COST    = 1,
  parameter int MISS_COST   = 5,
  localparam int EXTRA      = MISS_COST - HIT_COST,
  localparam int STALL_W    = $clog2(EXTRA + 1),
  localparam int COST_W     = $clog2(MISS_COST + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               br_valid_i,
  input  logic [DISP_W-1:0]  br_disp_i,
  input  logic               fwd_ctl_i,
  input  logic               res_valid_i,
  input  logic               res_taken_i,
  output logic               pred_taken_o,
  output logic               mispredict_o,
  output logic [COST_W-1:0]  cost_o,
  output logic [STALL_W-1:0] stall_cnt_o,
  output logic               fetch_rdy_o
);
  import sbp_pkg::*;

  logic      guess;
  logic      pend_q;
  logic      accept, resolve;
  res_kind_e kind;

  sbp_dir #(.DISP_W(DISP_W)) u_dir (
    .disp_i    (br_disp_i),
    .fwd_ctl_i (fwd_ctl_i),
    .taken_o   (guess)
  );

  assign accept  = br_valid_i  & ~pend_q;
  assign resolve = res_valid_i &  pend_q;

  sbp_hold u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept_i  (accept),
    .resolve_i (resolve),
    .pred_i    (guess),
    .pend_o    (pend_q),
    .pred_o    (pred_taken_o)
  );

  always_comb begin
    kind = RES_NONE;
    if (resolve) kind = (res_taken_i != pred_taken_o) ? RES_MISS : RES_HIT;
  end

  always_comb begin
    mispredict_o = (kind == RES_MISS);
    unique case (kind)
      RES_HIT:  cost_o = COST_W'(HIT_COST);
      RES_MISS: cost_o = COST_W'(MISS_COST);
      default:  cost_o = '0;
    endcase
  end

  sbp_penalty #(.EXTRA(EXTRA), .STALL_W(STALL_W)) u_pen (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (mispredict_o),
    .cnt_o  (stall_cnt_o),
    .rdy_o  (fetch_rdy_o)
  );
endmodule

// File: rtl/sbp_chk.sv
module sbp_chk #(
  parameter int MISS_COST = 5,
  parameter int EXTRA     = 4,
  parameter int COST_W    = 3,
  parameter int STALL_W   = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               res_valid_i,
  input logic               pend_q,
  input logic               pred_taken_o,
  input logic               mispredict_o,
  input logic [COST_W-1:0]  cost_o,
  input logic [STALL_W-1:0] stall_cnt_o,
  input logic               fetch_rdy_o
);
  // R5
  mispredict_needs_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict_o |-> (res_valid_i && pend_q));

  // R6
  miss_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict_o |-> (cost_o == COST_W'(MISS_COST)));

  // R4
  pred_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !res_valid_i) |=> (pend_q && $stable(pred_taken_o)));

  // R8
  idle_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |-> (cost_o == '0 && !mispredict_o));

  // R7
  stall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict_o |=> (stall_cnt_o == STALL_W'(EXTRA)));

  // R7
  stall_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt_o != '0 && !mispredict_o) |=> (stall_cnt_o == $past(stall_cnt_o) - 1'b1));

  // R7
  ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_cnt_o != '0) |-> !fetch_rdy_o);
endmodule

bind sbp_top sbp_chk #(
  .MISS_COST (MISS_COST),
  .EXTRA     (EXTRA),
  .COST_W    (COST_W),
  .STALL_W   (STALL_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .res_valid_i  (res_valid_i),
  .pend_q       (pend_q),
  .pred_taken_o (pred_taken_o),
  .mispredict_o (mispredict_o),
  .cost_o       (cost_o),
  .stall_cnt_o  (stall_cnt_o),
  .fetch_rdy_o  (fetch_rdy_o)
);

// File: tb/tb_sbp_top.sv
`timescale 1ns/1ps
module tb_sbp_top;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          br_valid_i = 1'b0;
  logic [DW-1:0] br_disp_i = '0;
  logic          fwd_ctl_i = 1'b0;
  logic          res_valid_i = 1'b0;
  logic          res_taken_i = 1'b0;
  logic          pred_taken_o, mispredict_o, fetch_rdy_o;
  logic [2:0]    cost_o, stall_cnt_o;

  sbp_top #(.DISP_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .br_valid_i(br_valid_i), .br_disp_i(br_disp_i),
    .fwd_ctl_i(fwd_ctl_i), .res_valid_i(res_valid_i), .res_taken_i(res_taken_i),
    .pred_taken_o(pred_taken_o), .mispredict_o(mispredict_o), .cost_o(cost_o),
    .stall_cnt_o(stall_cnt_o), .fetch_rdy_o(fetch_rdy_o)
  );

  always #2.5 clk = ~clk;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  // behavioural reference state
  bit m_pend = 0;
  bit m_pred = 0;
  int m_stall = 0;

  task automatic cmp(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit bv, int disp, bit ctl, bit rv, bit rt);
    bit resolve, miss, acc;
    int exp_cost;
    @(negedge clk);
    br_valid_i  = bv;
    br_disp_i   = DW'(disp);
    fwd_ctl_i   = ctl;
    res_valid_i = rv;
    res_taken_i = rt;
    #1;
    resolve  = rv && m_pend;
    acc      = bv && !m_pend;
    miss     = resolve && (rt != m_pred);
    exp_cost = !resolve ? 0 : (miss ? 5 : 1);
    cmp(tag, "pred_taken_o", int'(pred_taken_o), int'(m_pred));
    cmp(tag, "mispredict_o", int'(mispredict_o), int'(miss));
    cmp(tag, "cost_o",       int'(cost_o), exp_cost);
    cmp(tag, "stall_cnt_o",  int'(stall_cnt_o), m_stall);
    cmp(tag, "fetch_rdy_o",  int'(fetch_rdy_o), int'(m_stall == 0));
    @(posedge clk);
    if (resolve) m_pend = 0;
    else if (acc) begin
      m_pend = 1;
      m_pred = (disp < 0) ? 1'b1 : ctl;
    end
    if (miss) m_stall = 4;
    else if (m_stall > 0) m_stall = m_stall - 1;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    step("R1", 0, 0, 0, 0, 0);
    // R8 resolution with nothing pending
    step("R8", 0, 0, 0, 1, 1);
    step("R8", 0, 0, 0, 1, 0);
    // R2 backward, control bit 0, correct taken
    step("R2", 1, -8, 0, 0, 0);
    idle("R2", 2);
    step("R6", 0, 0, 0, 1, 1);
    // R3 forward with control 0 -> not taken, correct
    step("R3", 1, 12, 0, 0, 0);
    step("R6", 0, 0, 0, 1, 0);
    // R3 forward with control 1 -> taken, resolves not taken: miss
    step("R3", 1, 40, 1, 0, 0);
    step("R5", 0, 0, 0, 1, 0);
    idle("R7", 6);
    // R3 zero displacement counts as forward
    step("R3", 1, 0, 0, 0, 0);
    step("R5", 0, 0, 0, 1, 1);
    // R4 new branch while pending is ignored (mid-stall accept allowed)
    step("R4", 1, -2, 1, 0, 0);
    step("R4", 1, 100, 0, 0, 0);
    step("R4", 1, 7, 0, 0, 0);
    step("R4", 0, 0, 0, 1, 0);
    // R7 back-to-back mispredict reloads counter
    step("R7", 1, 5, 1, 0, 0);
    step("R7", 0, 0, 0, 1, 0);
    step("R7", 1, -1, 0, 0, 0);
    step("R7", 0, 0, 0, 1, 0);
    idle("R7", 6);
    // R5 random traffic
    for (int k = 0; k < 2000; k++) begin
      step("R5", bit'($urandom_range(0, 1)), $urandom_range(0, 200) - 100,
           bit'($urandom_range(0, 1)), bit'($urandom_range(0, 2) == 0),
           bit'($urandom_range(0, 1)));
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule